// File: doc/BRIEF.md
# Three-wire serial EEPROM target

This block is a synthesizable model of a serial EEPROM on the target side of a three-wire link. A host drives chip select, a serial clock and a serial data line. The block drives a serial data output together with an output-enable, so that the pad can be tri-stated. Register storage inside the block holds the word array. The `WIDE_ORG` parameter picks 16-bit words with `BASE_ADDR_W` address bits, or 8-bit words with one extra address bit. The three inputs pass through a two-flop synchronizer. Serial-clock rising edges are detected against the faster system clock `clk`.

Each command begins with a start bit. A 2-bit opcode follows, then the address and, for the two write forms, one data word. Four commands use the opcode 00. For these, the two upper address bits pick the command: programming enable, programming disable, erase-all or write-all. Erase, write, erase-all and write-all are only armed while the programming-enable latch is set. They then run a self-timed cycle that starts when chip select falls. The cycle keeps running after the target is deselected. While it runs, the target can be polled for ready/busy status on the output.

The control FSM has six states. `ST_IDLE` waits for a start bit. `ST_OPC` takes the two opcode bits. `ST_ADDR` takes the address bits. `ST_DATA` takes the write word. `ST_READ` streams words out. `ST_DONE` ignores the serial lines until chip select falls. The transitions are:
- IDLE to OPC, on a serial-clock rise with the data input high and no cycle running.
- OPC to ADDR, after the second opcode bit.
- ADDR to READ, DATA or DONE, on the last address bit, depending on the decoded command.
- DATA to DONE, on the last data bit.
- Any state to IDLE, whenever chip select is low.

Top module: `mw_eeprom_target`

## Requirements
- R1: The start condition is the first serial-clock rise at which chip select and the data input are both high. Clocks with the data input low before that cause no action.
- R2: Opcode encodings are 10 read, 01 write, 11 erase and 00 extended. For extended commands the two most significant address bits give 11 programming enable, 10 erase-all, 01 write-all and 00 programming disable. The address is sent MSB first (6 bits in the 16-bit organisation) and is followed, for the write forms, by the data word MSB first.
- R3: After reset the programming latch is clear, every word reads as all ones, and the output is not enabled.
- R4: While the latch is clear, erase, write, erase-all and write-all change no word and start no cycle, so no status appears. Read works in either latch state.
- R5: On the serial-clock rise that carries the last address bit of a read, the output is enabled and drives a single 0. Each following rise drives the next word bit, MSB first.
- R6: While chip select stays high, the words at the following addresses come out back to back with no extra 0 bit. The address wraps from the last word to word 0.
- R7: Write stores the word at the address. Erase sets the addressed word to all ones. Erase-all sets every word to all ones. Write-all stores the word at every address.
- R8: A programming cycle starts only on the chip-select fall after the last required bit. A command cut short is not executed.
- R9: While a cycle is running or has finished, and chip select is high again after its fall, the output is enabled and shows 0 for busy and 1 for ready. Once chip select is low, the output is disabled.
- R10: During a cycle, start bits are ignored. The cycle runs to completion whatever chip select and the serial clock do.
- R11: A cycle lasts `T_UNIT` system clocks for erase or write, 2×`T_UNIT` for erase-all and 4×`T_UNIT` for write-all.
- R12: After the last required bit of a command, further serial-clock and data activity is ignored until chip select falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Chip select, active high (asynchronous) |
| sclk_i | input | 1 | Serial clock from the host (asynchronous) |
| sdi_i | input | 1 | Serial data in (asynchronous) |
| sdo_o | output | 1 | Serial data out: read bits, or status 0 busy / 1 ready |
| sdo_oe_o | output | 1 | Output enable for `sdo_o`; low means high-Z |

## Verification
The bench checks the leading 0 of a read and then reads through the whole array past the last word. A design that sends a second 0 before later words fails here, and so does one whose address does not wrap. Commands cut short and commands sent while the latch is clear must leave the stored words untouched and must not enable status. A design that arms on partial bits or ignores the latch changes a word or drives the output when it should not. Start bits are sent while write-all is busy, and the status must stay busy. Extra clocks follow an erase, and the two neighbouring words are checked so that a design that re-arms on trailing bits is caught. The length of each cycle is measured from the chip-select fall to the first ready, so a design with a wrong duration for any command class fails.

// File: rtl/mw_eeprom_pkg.sv
`timescale 1ns/1ps
package mw_eeprom_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_OPC, ST_ADDR, ST_DATA, ST_READ, ST_DONE
    } mw_state_t;

    typedef enum logic [2:0] {
        PG_NONE, PG_ERASE, PG_WRITE, PG_ERAL, PG_WRAL
    } pg_op_t;

    localparam logic [1:0] OPC_EXT   = 2'b00;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_ERASE = 2'b11;

    localparam logic [1:0] SUB_DIS   = 2'b00;
    localparam logic [1:0] SUB_WALL  = 2'b01;
    localparam logic [1:0] SUB_EALL  = 2'b10;
    localparam logic [1:0] SUB_EN    = 2'b11;
endpackage

// File: rtl/mw_sync.sv
`timescale 1ns/1ps
module mw_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [STAGES-1:0][WIDTH-1:0] stg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= '0;
        else        stg <= {stg[STAGES-2:0], d_i};
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/mw_prog_timer.sv
`timescale 1ns/1ps
module mw_prog_timer #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             busy_o,
    output logic             done_o
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt <= '0;
        else if (start_i)       cnt <= len_i;
        else if (cnt != '0)     cnt <= cnt - 1'b1;
    end

    assign busy_o = (cnt != '0);
    assign done_o = (cnt == CNT_W'(1));

    // R10
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_o);

    // R11
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(done_o));
endmodule

// File: rtl/mw_eeprom_target.sv
`timescale 1ns/1ps
module mw_eeprom_target
    import mw_eeprom_pkg::*;
#(
    parameter bit WIDE_ORG    = 1'b1,
    parameter int BASE_ADDR_W = 6,
    parameter int T_UNIT      = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_i,
    input  logic sclk_i,
    input  logic sdi_i,
    output logic sdo_o,
    output logic sdo_oe_o
);
    localparam int WORD_W = WIDE_ORG ? 16 : 8;
    localparam int ADDR_W = WIDE_ORG ? BASE_ADDR_W : BASE_ADDR_W + 1;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int CNT_W  = $clog2(4 * T_UNIT + 1);
    localparam int MAXB   = (WORD_W > ADDR_W) ? WORD_W : ADDR_W;
    localparam int BIT_W  = $clog2(MAXB + 1);

    // input synchronisation and edge detection
    logic [2:0] sy;
    logic cs_s, ck_s, di_s, cs_q, ck_q, ck_rise, cs_fall;

    mw_sync #(.WIDTH(3), .STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i({sel_i, sclk_i, sdi_i}), .q_o(sy));

    assign {cs_s, ck_s, di_s} = sy;
    assign ck_rise = ck_s & ~ck_q;
    assign cs_fall = cs_q & ~cs_s;

    mw_state_t st, st_nxt;
    logic [BIT_W-1:0]  bit_cnt;
    logic [1:0]        opc;
    logic [ADDR_W-1:0] addr_sr, prog_addr;
    logic [WORD_W-1:0] data_sr, rd_sr, prog_data;
    logic              dout, wen, stat_mode;
    pg_op_t            pend, prog_op;
    logic [WORD_W-1:0] mem [DEPTH];

    logic [ADDR_W-1:0] addr_full, addr_inc;
    logic [WORD_W-1:0] data_full;
    logic [1:0]        sub;
    logic              last_addr, last_data, prog_start, tmr_busy, tmr_done;
    logic [CNT_W-1:0]  prog_len;

    assign addr_full  = {addr_sr[ADDR_W-2:0], di_s};
    assign addr_inc   = addr_sr + 1'b1;
    assign data_full  = {data_sr[WORD_W-2:0], di_s};
    assign sub        = addr_full[ADDR_W-1 -: 2];
    assign last_addr  = cs_s && ck_rise && st == ST_ADDR && bit_cnt == BIT_W'(ADDR_W - 1);
    assign last_data  = cs_s && ck_rise && st == ST_DATA && bit_cnt == BIT_W'(WORD_W - 1);
    assign prog_start = cs_fall && st == ST_DONE && pend != PG_NONE;

    always_comb begin
        unique case (pend)
            PG_ERAL: prog_len = CNT_W'(2 * T_UNIT);
            PG_WRAL: prog_len = CNT_W'(4 * T_UNIT);
            default: prog_len = CNT_W'(T_UNIT);
        endcase
    end

    mw_prog_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .start_i(prog_start), .len_i(prog_len),
        .busy_o(tmr_busy), .done_o(tmr_done));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    // next-state logic
    always_comb begin
        st_nxt = st;
        if (!cs_s) begin
            st_nxt = ST_IDLE;
        end else if (ck_rise) begin
            unique case (st)
                ST_IDLE: if (di_s && !tmr_busy) st_nxt = ST_OPC;
                ST_OPC:  if (bit_cnt == BIT_W'(1)) st_nxt = ST_ADDR;
                ST_ADDR: if (bit_cnt == BIT_W'(ADDR_W - 1)) begin
                    if (opc == OPC_READ)                         st_nxt = ST_READ;
                    else if (opc == OPC_WRITE)                   st_nxt = ST_DATA;
                    else if (opc == OPC_EXT && sub == SUB_WALL)  st_nxt = ST_DATA;
                    else                                         st_nxt = ST_DONE;
                end
                ST_DATA: if (bit_cnt == BIT_W'(WORD_W - 1)) st_nxt = ST_DONE;
                ST_READ, ST_DONE: st_nxt = st;
                default: st_nxt = ST_IDLE;
            endcase
        end
    end

    // shift, decode and command datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ck_q <= 1'b0;  cs_q <= 1'b0;  bit_cnt <= '0;  opc <= '0;
            addr_sr <= '0; data_sr <= '0; rd_sr <= '0;   dout <= 1'b0;
            wen <= 1'b0;   pend <= PG_NONE; stat_mode <= 1'b0;
            prog_op <= PG_NONE; prog_addr <= '0; prog_data <= '0;
        end else begin
            ck_q <= ck_s;
            cs_q <= cs_s;
            if (prog_start) begin
                prog_op   <= pend;
                prog_addr <= addr_sr;
                prog_data <= data_sr;
            end
            if (prog_start)
                stat_mode <= 1'b1;
            else if ((cs_fall && !tmr_busy) || (st == ST_IDLE && st_nxt == ST_OPC))
                stat_mode <= 1'b0;

            if (!cs_s) begin
                bit_cnt <= '0;
                pend    <= PG_NONE;
            end else if (ck_rise) begin
                unique case (st)
                    ST_OPC: begin
                        opc     <= {opc[0], di_s};
                        bit_cnt <= (st_nxt != st) ? '0 : bit_cnt + 1'b1;
                    end
                    ST_ADDR: begin
                        addr_sr <= addr_full;
                        bit_cnt <= (st_nxt != st) ? '0 : bit_cnt + 1'b1;
                        if (last_addr) begin
                            if (opc == OPC_READ) begin
                                rd_sr <= mem[addr_full];
                                dout  <= 1'b0;
                            end else if (opc == OPC_ERASE && wen) begin
                                pend <= PG_ERASE;
                            end else if (opc == OPC_EXT) begin
                                if (sub == SUB_EN)               wen  <= 1'b1;
                                if (sub == SUB_DIS)              wen  <= 1'b0;
                                if (sub == SUB_EALL && wen)      pend <= PG_ERAL;
                            end
                        end
                    end
                    ST_DATA: begin
                        data_sr <= data_full;
                        bit_cnt <= (st_nxt != st) ? '0 : bit_cnt + 1'b1;
                        if (last_data && wen)
                            pend <= (opc == OPC_WRITE) ? PG_WRITE : PG_WRAL;
                    end
                    ST_READ: begin
                        dout <= rd_sr[WORD_W-1];
                        if (bit_cnt == BIT_W'(WORD_W - 1)) begin
                            bit_cnt <= '0;
                            addr_sr <= addr_inc;
                            rd_sr   <= mem[addr_inc];
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                            rd_sr   <= {rd_sr[WORD_W-2:0], 1'b0};
                        end
                    end
                    ST_IDLE, ST_DONE: bit_cnt <= '0;
                    default: bit_cnt <= '0;
                endcase
            end
        end
    end

    // array: committed at the end of the self-timed cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (tmr_done) begin
            unique case (prog_op)
                PG_ERASE: mem[prog_addr] <= '1;
                PG_WRITE: mem[prog_addr] <= prog_data;
                PG_ERAL:  for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
                PG_WRAL:  for (int i = 0; i < DEPTH; i++) mem[i] <= prog_data;
                default:  ;
            endcase
        end
    end

    // outputs
    always_comb begin
        sdo_oe_o = (st == ST_READ) || (stat_mode && cs_s && st == ST_IDLE);
        sdo_o    = (st == ST_READ) ? dout : !tmr_busy;
    end

    // R9
    oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_s && !cs_q) |-> !sdo_oe_o);

    // R4
    prog_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> wen);

    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_busy |-> (st == ST_IDLE));

    // R5
    dummy_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_READ && $past(st) == ST_ADDR) |-> (sdo_oe_o && !sdo_o));
endmodule

// File: tb/mw_eeprom_target_test.sv
`timescale 1ns/1ps
module mw_eeprom_target_test;
    localparam int W  = 16;
    localparam int A  = 6;
    localparam int D  = 64;
    localparam int TU = 24;

    logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sck = 1'b0, di = 1'b0;
    logic sdo, sdo_oe;
    logic last_q, last_oe;
    int   n_chk = 0, n_fail = 0;
    logic [W-1:0] model [D];

    always #2.5 clk = ~clk;

    mw_eeprom_target #(.WIDE_ORG(1'b1), .BASE_ADDR_W(A), .T_UNIT(TU)) uut (
        .clk(clk), .rst_n(rst_n), .sel_i(cs), .sclk_i(sck), .sdi_i(di),
        .sdo_o(sdo), .sdo_oe_o(sdo_oe));

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clk_bit(input logic b);
        di = b; ticks(4);
        sck = 1'b1; ticks(5);
        last_q = sdo; last_oe = sdo_oe;
        sck = 1'b0; ticks(1);
    endtask

    task automatic send(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) clk_bit(v[i]);
    endtask

    task automatic select();
        cs = 1'b1; ticks(4);
    endtask

    task automatic deselect();
        sck = 1'b0; di = 1'b0; cs = 1'b0; ticks(10);
    endtask

    task automatic cmd_hdr(input logic [1:0] op, input logic [A-1:0] a);
        send({23'd0, 1'b1, op, a}, 3 + A);
    endtask

    task automatic rd_seq(input int a0, input int n, input string tag);
        logic [W-1:0] w;
        select();
        cmd_hdr(2'b10, A'(a0));
        chk(last_oe && !last_q, "R5 dummy zero", {last_oe, last_q}, 2'b10);
        for (int k = 0; k < n; k++) begin
            w = '0;
            for (int b = 0; b < W; b++) begin
                clk_bit(1'b0);
                w = {w[W-2:0], last_q};
            end
            chk(w == model[(a0 + k) % D], tag, w, model[(a0 + k) % D]);
        end
        deselect();
    endtask

    task automatic wait_ready(input int len, input string tag);
        int t;
        bit seen;
        cs = 1'b1; ticks(4);
        t = 14; seen = 1'b0;
        if (len > 0) chk(sdo_oe && !sdo, tag, {sdo_oe, sdo}, 2'b10);
        while (!seen && t < 800) begin
            if (sdo_oe && sdo) seen = 1'b1;
            else begin ticks(1); t++; end
        end
        chk(seen, tag, 32'(seen), 1);
        if (len > 0) chk(t >= len && t <= len + 10, "R11 cycle length", t, len);
        deselect();
    endtask

    task automatic no_status(input string tag);
        cs = 1'b1; ticks(6);
        chk(!sdo_oe, tag, 32'(sdo_oe), 0);
        deselect();
    endtask

    task automatic wr(input int a, input logic [W-1:0] d, input int lead);
        select();
        if (lead > 0) send(32'd0, lead);
        cmd_hdr(2'b01, A'(a));
        send({16'd0, d}, W);
        deselect();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < D; i++) model[i] = '1;
        ticks(5); rst_n = 1'b1; ticks(3);

        // R3: released output and erased array after reset, wrap at the end (R6)
        chk(!sdo_oe, "R3 output released after reset", 32'(sdo_oe), 0);
        rd_seq(0, D + 1, "R3 erased contents / R6 wrap");

        // R4: write while latch clear is ignored
        wr(5, 16'h1234, 0);
        no_status("R4 no status while disabled");
        rd_seq(5, 1, "R4 word unchanged");

        // R1: clocks with data low before start, then enable (R2 sub 11)
        select();
        send(32'd0, 5);
        cmd_hdr(2'b00, 6'b110000);
        deselect();

        // R2/R7: write every address, R9 status and R11 length each time
        for (int a = 0; a < D; a++) begin
            logic [W-1:0] d;
            d = W'(a * 16'h0301) ^ 16'hA55A;
            wr(a, d, (a == 0) ? 3 : 0);
            wait_ready(TU, (a == 0) ? "R1 start after idle clocks" : "R9 busy then ready");
            model[a] = d;
        end
        rd_seq(0, D + 1, "R2 R7 stored words, R6 sequential");

        // R8: write cut short after 10 data bits, address cut short
        select(); cmd_hdr(2'b01, 6'd9); send(32'd0, 10); deselect();
        no_status("R8 truncated write no status");
        select(); send(32'b1110, 4); deselect();
        no_status("R8 truncated erase no status");
        rd_seq(9, 1, "R8 word unchanged");

        // R12: erase followed by extra clocks with data high
        select(); cmd_hdr(2'b11, 6'd10); send(32'hFFF, 12); deselect();
        wait_ready(TU, "R12 erase status");
        model[10] = '1;
        rd_seq(9, 3, "R12 only addressed word erased");

        // R7: erase-all, length 2 units
        select(); cmd_hdr(2'b00, 6'b100000); deselect();
        wait_ready(2 * TU, "R7 erase-all status");
        for (int i = 0; i < D; i++) model[i] = '1;
        rd_seq(0, D, "R7 erase-all contents");

        // R10: write-all, start bits while busy keep busy status, CS toggled
        select(); cmd_hdr(2'b00, 6'b010000); send(32'h3C3C, W); deselect();
        cs = 1'b1; ticks(2);
        for (int b = 0; b < 3; b++) begin
            clk_bit(b[0] ? 1'b0 : 1'b1);
            chk(last_oe && !last_q, "R10 start ignored while busy", {last_oe, last_q}, 2'b10);
        end
        deselect();
        wait_ready(0, "R10 cycle completes after deselect");
        for (int i = 0; i < D; i++) model[i] = 16'h3C3C;
        rd_seq(0, D, "R7 write-all contents");

        // write-all length 4 units
        select(); cmd_hdr(2'b00, 6'b010000); send(32'hC3C3, W); deselect();
        wait_ready(4 * TU, "R11 write-all status");
        for (int i = 0; i < D; i++) model[i] = 16'hC3C3;

        // R4: disable, then write and erase ignored, read still works
        select(); cmd_hdr(2'b00, 6'b000000); deselect();
        wr(7, 16'h0000, 0);
        no_status("R4 write ignored after disable");
        select(); cmd_hdr(2'b11, 6'd8); deselect();
        no_status("R4 erase ignored after disable");
        rd_seq(7, 2, "R4 read while disabled");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule